// File: doc/BRIEF.md
# Coded-Ratio Clock Divider

This block divides a clock by a ratio that comes from a 3-bit code. The code is not used as a count. It selects one of eight entries in a fixed table, and the table can repeat ratios and contain odd ones. A parameter picks which of four tables is built in. A gate enable sits in front of the divider, so the derived clock can be stopped and restarted without a reset.

Each "source" is an advance strobe that is synchronous to the block clock. In the variant with a source select, select 0 advances the divider on every second clock edge, which gives the primary clock divided by two. Select 1 advances it only on edges where the second-source strobe is high. The variant without a select advances on every clock edge.

A new code is adopted only when the current output period ends. Integrators can therefore rewrite the code at any time without producing a shortened pulse. Stopping the gate discards the period in progress. Re-enabling starts a fresh period from its high phase, using the code present at that moment.

Top module: `coded_clk_div`

## Requirements
- R1: While `rst` is sampled high, and on the cycle after it, `divClk` is low. The first edge after release with `gateEn` high loads the ratio for the code present at that edge and starts position 0.
- R2: With `PROFILE` = 0, codes 0..7 give ratios 2, 2, 3, 4, 5, 6, 7, 8.
- R3: With `PROFILE` = 1, codes 0..7 give ratios 2, 4, 6, 8, 10, 12, 14, 16.
- R4: With `PROFILE` = 2, codes 0..7 give ratios 4, 4, 6, 8, 10, 12, 14, 16.
- R5: With `PROFILE` = 3, codes 0..7 give ratios 4, 8, 12, 16, 20, 24, 28, 32.
- R6: An output period is `ratio` count positions long. The output is high for the first floor(ratio/2) positions and low for the rest. Even ratios therefore give 50% duty, and an odd ratio r gives (r-1)/2 high positions.
- R7: When `gateEn` is sampled low, `divClk` is low from the next cycle on and the count returns to position 0. After `gateEn` is sampled high again, a new period starts at its high phase on the next cycle, using the code sampled at that edge.
- R8: A change of `code` while the gate is open takes effect only when the last position of the current period is left. The ratio never changes in mid-period.
- R9: In the select variant with `srcSel` = 0, each count position lasts exactly two clock cycles.
- R10: In the select variant with `srcSel` = 1, the count advances only on edges where `altTick` is high. All other positions hold.
- R11: With `HAS_SRC_SEL` = 0, the count advances on every clock edge and `srcSel` and `altTick` have no effect on `divClk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (primary source) |
| rst | input | 1 | Synchronous reset, active high |
| gateEn | input | 1 | Gate enable; low stops the output |
| srcSel | input | 1 | Source select: 0 = primary / 2, 1 = second source (select variant only) |
| altTick | input | 1 | Second-source advance strobe, synchronous to `clk` |
| code | input | 3 | Ratio code, looked up in the profile table |
| divClk | output | 1 | Divided clock |

## Verification
The case that is hardest to reach from the ports is a code change on the edge where a period wraps. The same applies to a gate drop on that edge, and to a source switch while a half-rate position is half spent. Each of these has to land at one exact phase of a counter that cannot be seen from outside. To reach them, the stimulus changes code, gate and select at random on every cycle over long runs. Four instances, one per profile, see the same inputs. A behavioural model follows each instance position by position and is compared on every clock, so every wrap-edge coincidence that occurs is checked. Directed windows after reset add hand-computed high-cycle counts for several ratios.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int CODE_W  = 3;
  localparam int MAX_RATIO = 32;
  localparam int RATIO_W = $clog2(MAX_RATIO + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic run;    // gate open (registered)
    logic clear;  // hold position 0, reload ratio
    logic step;   // advance one count position
  } divStrobe_t;

  // profile table lookup
  function automatic logic [RATIO_W-1:0] ratioFor(input int profile,
                                                  input logic [CODE_W-1:0] code);
    int c;
    int r;
    c = int'(code);
    case (profile)
      0:       r = (c < 2) ? 2 : c + 1;
      1:       r = 2 * (c + 1);
      2:       r = (c < 2) ? 4 : 2 * (c + 1);
      default: r = 4 * (c + 1);
    endcase
    return RATIO_W'(r);
  endfunction

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import clkdiv_pkg::*;
#(
  parameter bit HAS_SRC_SEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gateEn,
  input  logic       srcSel,
  input  logic       altTick,
  output divStrobe_t strb
);

  logic gateQ;
  logic halfQ;
  logic tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      gateQ <= 1'b0;
      halfQ <= 1'b0;
    end else begin
      gateQ <= gateEn;
      halfQ <= gateQ ? ~halfQ : 1'b0;
    end
  end

  generate
    if (HAS_SRC_SEL) begin : g_sel
      assign tick = srcSel ? altTick : halfQ;
    end else begin : g_direct
      assign tick = 1'b1;
    end
  endgenerate

  assign strb.run   = gateQ;
  assign strb.clear = ~gateQ;
  assign strb.step  = gateQ & tick;

  // R9: half-rate source never steps on two consecutive edges
  p_half_rate_r9: assert property (@(posedge clk) disable iff (rst)
    (HAS_SRC_SEL && !srcSel && strb.step) |=> !(strb.step && !srcSel));

  // R10: second source holds the count when its strobe is low
  p_alt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (HAS_SRC_SEL && srcSel && !altTick) |-> !strb.step);

endmodule

// File: rtl/div_path.sv
module div_path
  import clkdiv_pkg::*;
#(
  parameter int PROFILE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  divStrobe_t        strb,
  output logic              divClk
);

  logic [RATIO_W-1:0] cntQ;
  logic [RATIO_W-1:0] ratioQ;
  logic [RATIO_W-1:0] highLen;
  logic               lastPos;

  assign lastPos = (cntQ == ratioQ - RATIO_W'(1));
  assign highLen = ratioQ >> 1;

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      cntQ   <= '0;
      ratioQ <= ratioFor(PROFILE, code);
    end else if (strb.step) begin
      if (lastPos) begin
        cntQ   <= '0;
        ratioQ <= ratioFor(PROFILE, code);
      end else begin
        cntQ <= cntQ + RATIO_W'(1);
      end
    end
  end

  assign divClk = strb.run && (cntQ < highLen);

  // R6: position always inside the period
  p_pos_in_period_r6: assert property (@(posedge clk) disable iff (rst)
    cntQ < ratioQ);

  // R8: ratio only changes when the last position is left
  p_ratio_at_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    (strb.run && $past(strb.run) && ratioQ != $past(ratioQ))
      |-> ($past(cntQ) == $past(ratioQ) - RATIO_W'(1)));

endmodule

// File: rtl/coded_clk_div.sv
module coded_clk_div
  import clkdiv_pkg::*;
#(
  parameter int PROFILE     = 0,
  parameter bit HAS_SRC_SEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gateEn,
  input  logic              srcSel,
  input  logic              altTick,
  input  logic [CODE_W-1:0] code,
  output logic              divClk
);

  divStrobe_t strb;

  div_ctrl #(.HAS_SRC_SEL(HAS_SRC_SEL)) u_ctrl (
    .clk(clk), .rst(rst), .gateEn(gateEn),
    .srcSel(srcSel), .altTick(altTick), .strb(strb)
  );

  div_path #(.PROFILE(PROFILE)) u_path (
    .clk(clk), .rst(rst), .code(code), .strb(strb), .divClk(divClk)
  );

  // R1: output low the cycle after reset is sampled
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !divClk);

  // R7: closed gate forces the output low on the next cycle
  p_gate_low_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!gateEn) |-> !divClk);

endmodule

// File: tb/sim_coded_clk_div.sv
module sim_coded_clk_div;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gateEn = 1'b0;
  logic srcSel = 1'b0;
  logic altTick = 1'b0;
  logic [2:0] code = 3'd0;
  logic [NI-1:0] outs;

  always #(CLK_PERIOD/2) clk = ~clk;

  coded_clk_div #(.PROFILE(0), .HAS_SRC_SEL(1'b1)) u0 (.clk(clk), .rst(rst), .gateEn(gateEn),
    .srcSel(srcSel), .altTick(altTick), .code(code), .divClk(outs[0]));
  coded_clk_div #(.PROFILE(1), .HAS_SRC_SEL(1'b0)) u1 (.clk(clk), .rst(rst), .gateEn(gateEn),
    .srcSel(srcSel), .altTick(altTick), .code(code), .divClk(outs[1]));
  coded_clk_div #(.PROFILE(2), .HAS_SRC_SEL(1'b0)) u2 (.clk(clk), .rst(rst), .gateEn(gateEn),
    .srcSel(srcSel), .altTick(altTick), .code(code), .divClk(outs[2]));
  coded_clk_div #(.PROFILE(3), .HAS_SRC_SEL(1'b0)) u3 (.clk(clk), .rst(rst), .gateEn(gateEn),
    .srcSel(srcSel), .altTick(altTick), .code(code), .divClk(outs[3]));

  int nCompared = 0;
  int nMismatch = 0;
  bit armed = 1'b0;
  bit done = 1'b0;
  string phase = "R1";
  string profTag [NI] = '{"R2", "R3", "R4", "R5"};

  // profile tables written from the requirements
  int tabA [8] = '{2, 2, 3, 4, 5, 6, 7, 8};
  int tabB [8] = '{2, 4, 6, 8, 10, 12, 14, 16};
  int tabC [8] = '{4, 4, 6, 8, 10, 12, 14, 16};
  int tabD [8] = '{4, 8, 12, 16, 20, 24, 28, 32};

  function automatic int lookRatio(int k, int c);
    case (k)
      0: return tabA[c];
      1: return tabB[c];
      2: return tabC[c];
      default: return tabD[c];
    endcase
  endfunction

  // behavioural model: one entry per instance
  int mOpen [NI];
  int mPos  [NI];
  int mLen  [NI];
  int mOdd  [NI];

  always @(posedge clk) begin
    for (int k = 0; k < NI; k++) begin
      bit adv;
      if (k == 0) adv = srcSel ? altTick : (mOdd[k] == 1);
      else        adv = 1'b1;
      if (rst) begin
        mOpen[k] = 0; mPos[k] = 0; mOdd[k] = 0;
        mLen[k] = lookRatio(k, int'(code));
      end else begin
        if (mOpen[k] == 0) begin
          mPos[k] = 0; mOdd[k] = 0;
          mLen[k] = lookRatio(k, int'(code));
        end else begin
          if (adv) begin
            if (mPos[k] + 1 == mLen[k]) begin
              mPos[k] = 0;
              mLen[k] = lookRatio(k, int'(code));
            end else begin
              mPos[k] = mPos[k] + 1;
            end
          end
          mOdd[k] = 1 - mOdd[k];
        end
        mOpen[k] = gateEn ? 1 : 0;
      end
    end
    armed = 1'b1;
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      for (int k = 0; k < NI; k++) begin
        logic expv;
        expv = (mOpen[k] == 1) && (mPos[k] < mLen[k] / 2);
        nCompared++;
        if (outs[k] !== expv) begin
          nMismatch++;
          $display("FAIL %s/%s u%0d t=%0t: divClk=%b expected %b",
                   phase, profTag[k], k, $time, outs[k], expv);
        end
      end
    end
  end

  task automatic check(string req, int act, int expv);
    nCompared++;
    if (act != expv) begin
      nMismatch++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic resetWith(int c);
    @(negedge clk);
    rst = 1'b1; code = 3'(c);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // high cycles of one output over a window starting at the first open cycle
  task automatic countHigh(int k, int win, output int cnt);
    cnt = 0;
    @(posedge clk);
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      cnt += outs[k];
    end
  endtask

  initial begin
    int h;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset low u0", int'(outs[0]), 0);
    check("R1 reset low u3", int'(outs[3]), 0);

    gateEn = 1'b1; srcSel = 1'b0;
    phase = "R6";
    // R3/R6: profile B code 2 -> ratio 6, two periods = 6 high of 12
    resetWith(2); countHigh(1, 12, h); check("R3 R6 u1 code2", h, 6);
    // R4/R6: profile C code 0 -> ratio 4
    resetWith(0); countHigh(2, 8, h); check("R4 R6 u2 code0", h, 4);
    // R5/R6: profile D code 1 -> ratio 8
    resetWith(1); countHigh(3, 16, h); check("R5 R6 u3 code1", h, 8);
    // R2/R6/R9: profile A code 2 -> ratio 3 odd, half rate: 2 high of 6 clk
    resetWith(2); countHigh(0, 12, h); check("R2 R6 R9 u0 code2 odd", h, 4);
    // R2/R9: code 0 -> ratio 2, 2 high of 4 clk
    resetWith(0); countHigh(0, 12, h); check("R2 R9 u0 code0", h, 6);
    // R1: first period uses code present at release (profile D code 7 -> 32)
    resetWith(7); countHigh(3, 32, h); check("R1 R5 u3 code7", h, 16);

    // R8: code changes every cycle with the gate open
    phase = "R8";
    for (int i = 0; i < 800; i++) begin
      @(negedge clk); code = 3'($urandom_range(0, 7));
    end

    // R7: gate toggled at random
    phase = "R7";
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      gateEn = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 3) == 0) code = 3'($urandom_range(0, 7));
    end
    gateEn = 1'b1;

    // R10/R11: second source on u0, ignored by u1..u3
    phase = "R10 R11";
    srcSel = 1'b1;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      altTick = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 7) == 0) code = 3'($urandom_range(0, 7));
    end

    // R9/R10: source select switched mid-position
    phase = "R9 R10";
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      srcSel = $urandom_range(0, 1) == 1;
      altTick = $urandom_range(0, 1) == 1;
      gateEn = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 5) == 0) code = 3'($urandom_range(0, 7));
    end

    // R1: reset mid-run
    phase = "R1";
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 low after reset u0", int'(outs[0]), 0);
    check("R1 low after reset u1", int'(outs[1]), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nMismatch++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

endmodule